// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits between a clocked host and an asynchronous pseudo-SRAM with a 20-bit word address and a 16-bit data bus. The host hands over one read or one write at a time through a valid/ready request that carries an address, write data and a two-bit lane mask. The controller turns each request into a complete sequence on the memory's active-low pins: chip enable, output enable, write enable and the lower and upper byte-lane enables. It also drives a direction control for the external tristate data bus. Read results come back on a data output qualified by a one-cycle valid strobe.

Every memory timing window is set by a nanosecond parameter. The controller turns it into a cycle count by rounding up against the clock period, so the same RTL can serve another clock or speed grade. After every access the controller parks chip enable high. This keeps the memory out of its output-disabled state, which it must not hold for long. It also gives the memory a quiet guard interval before the next access, so that no spurious write or unintended read can start.

Top module: `psram_async_ctrl`

## Requirements
- R1: While reset is asserted and right after it, memCeN, memOeN, memWeN, memLbN and memUbN are high, memDqOe and rdValid are low, and reqReady stays low until the post-reset guard interval has passed.
- R2: A request is accepted only on a clock edge where reqValid and reqReady are both high. reqReady stays low from acceptance until the access and its guard interval are over. memAddr holds the accepted address for the whole time memCeN is low.
- R3: A read drives memCeN and memOeN low together with memWeN high and keeps them low for at least ceil(70 ns / period) cycles (18 at 4 ns).
- R4: Read data is sampled ceil(65 ns / period) cycles after memCeN and memOeN fall (17 at 4 ns). It appears on rdData with rdValid high for exactly one cycle.
- R5: A write pulls memCeN and memWeN low together. memWeN stays low for the larger of ceil(45 ns / period) and ceil(15 ns / period) cycles (12 at 4 ns), and memCeN stays low for at least ceil(70 ns / period) cycles. reqBe bit 0 enables the low byte (memLbN low) and bit 1 the high byte (memUbN low); a 1 means that lane is written.
- R6: memDqOe is high, with the write data on memDqOut, exactly while memWeN is low during a write. memDqOe is never high while memOeN is low.
- R7: After memWeN rises, memCeN stays low for at least ceil(10 ns / period) cycles (3 at 4 ns) of write recovery.
- R8: After memCeN rises, memCeN, memOeN and memWeN all stay high for at least the largest of the 12 ns high-pulse, 10 ns write-enable guard and 12 ns output-enable setup counts (3 cycles at 4 ns) before memCeN falls again.
- R9: memCeN is never low for 1 us or longer. When no request is pending, memCeN stays high however long the idle time.
- R10: Reads ignore reqBe: both memLbN and memUbN are low whenever memCeN and memOeN are low, so a read with reqBe = 0 still returns the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Write lane mask, bit 0 low byte, bit 1 high byte |
| rdData | output | 16 | Captured read data |
| rdValid | output | 1 | One-cycle strobe qualifying rdData |
| memAddr | output | 20 | Memory address pins |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLbN | output | 1 | Low byte lane enable, active low |
| memUbN | output | 1 | High byte lane enable, active low |
| memDqOut | output | 16 | Data driven toward the memory |
| memDqOe | output | 1 | Enable of the external data bus driver |
| memDqIn | input | 16 | Data returned by the memory |

## Verification
The bench pairs a behavioural memory model with a pin monitor. The model returns a poison pattern until 65 ns have passed with chip and output enable both low, so a controller that samples one cycle early reads the poison instead of the stored word. The monitor measures every pulse and gap at the pins. It catches a write pulse that is too short, a chip enable that rises straight after write enable with no recovery, a guard interval where write or output enable moves, and a bus driver still on under an active output enable. Partial-lane writes followed by a read with an empty mask show whether lanes merge correctly and whether a read wrongly obeys the mask. A long idle stretch shows whether the controller leaves chip enable low while waiting.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  // Per-cycle commands from the sequencer to the pin datapath.
  typedef struct packed {
    logic ceLow;
    logic oeLow;
    logic weLow;
    logic dqDrive;
    logic loadReq;
    logic capture;
  } pinStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_ctrl_seq.sv
module psram_ctrl_seq
  import psram_ctrl_pkg::*;
#(
  parameter int WP_CYC  = 12,
  parameter int ACC_CYC = 17,
  parameter int RD_LEN  = 18,
  parameter int WR_LEN  = 18,
  parameter int GAP_LEN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output pinStrobe_t stb
);

  localparam int CNT_W = $clog2(maxOf(maxOf(RD_LEN, WR_LEN), GAP_LEN) + 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_LEN - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] WP_V     = CNT_W'(WP_CYC);
  localparam logic [CNT_W-1:0] ACC_V    = CNT_W'(ACC_CYC);

  typedef enum logic [1:0] {S_GAP, S_IDLE, S_ACC} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic [CNT_W-1:0] accLast;

  assign accLast  = isWrite ? WR_LAST : RD_LAST;
  assign reqReady = (state == S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_GAP;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      unique case (state)
        S_GAP: begin
          if (cnt == GAP_LAST) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_IDLE: begin
          if (reqValid) begin
            state   <= S_ACC;
            cnt     <= '0;
            isWrite <= reqWrite;
          end
        end
        S_ACC: begin
          if (cnt == accLast) begin
            state <= S_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= S_GAP;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.ceLow   = (state == S_ACC);
    stb.oeLow   = (state == S_ACC) && !isWrite;
    stb.weLow   = (state == S_ACC) && isWrite && (cnt < WP_V);
    stb.dqDrive = stb.weLow;
    stb.loadReq = (state == S_IDLE) && reqValid;
    stb.capture = (state == S_ACC) && !isWrite && (cnt == ACC_V);
  end

  // R2: an accepted request opens an access on the very next cycle
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadReq |=> (stb.ceLow && !reqReady));

  // R4: sampling only happens inside a read with outputs enabled
  assert_capture_in_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (stb.ceLow && stb.oeLow && !stb.weLow));

  // R2: no new request is taken while an access is running
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.ceLow |-> !reqReady);

endmodule

// File: rtl/psram_ctrl_dp.sv
module psram_ctrl_dp
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int GAP_LEN = 3,
  parameter int WR_CYC  = 3,
  parameter int CAP_CYC = 250
) (
  input  logic              clk,
  input  logic              rstN,
  input  pinStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [1:0] beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      beQ      <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memLbN   <= 1'b1;
      memUbN   <= 1'b1;
      memDqOe  <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (stb.loadReq) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
        beQ      <= reqBe;
      end
      memCeN  <= !stb.ceLow;
      memOeN  <= !stb.oeLow;
      memWeN  <= !stb.weLow;
      memDqOe <= stb.dqDrive;
      memLbN  <= !(stb.ceLow && (stb.oeLow || beQ[0]));
      memUbN  <= !(stb.ceLow && (stb.oeLow || beQ[1]));
      rdValid <= stb.capture;
      if (stb.capture) rdData <= memDqIn;
    end
  end

  // Pin-level run-length counters feeding the timing assertions below.
  localparam int MON_W = $clog2(CAP_CYC + 2);
  localparam logic [MON_W-1:0] CAP_V = MON_W'(CAP_CYC);
  localparam logic [MON_W-1:0] GAP_V = MON_W'(GAP_LEN);
  localparam logic [MON_W-1:0] WR_V  = MON_W'(WR_CYC);
  localparam logic [MON_W-1:0] SAT_V = '1;

  logic [MON_W-1:0] ceLowCnt;
  logic [MON_W-1:0] ceHighCnt;
  logic [MON_W-1:0] recovCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceLowCnt  <= '0;
      ceHighCnt <= '0;
      recovCnt  <= '0;
    end else begin
      ceLowCnt  <= memCeN ? '0 : ((ceLowCnt == SAT_V) ? SAT_V : ceLowCnt + 1'b1);
      ceHighCnt <= !memCeN ? '0 : ((ceHighCnt == SAT_V) ? SAT_V : ceHighCnt + 1'b1);
      recovCnt  <= (memCeN || !memWeN) ? '0
                 : ((recovCnt == SAT_V) ? SAT_V : recovCnt + 1'b1);
    end
  end

  // R9: output-disable style hold never reaches the 1 us cap
  assert_ce_low_cap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> (ceLowCnt < CAP_V));

  // R8: guard interval with chip enable high before each new access
  assert_ce_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> (ceHighCnt >= GAP_V));

  // R8: write and output enable stay high right after chip enable rises
  assert_quiet_after_ce_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> (memWeN && memOeN));

  // R7: write recovery before chip enable rises
  assert_write_recovery_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> (recovCnt >= WR_V));

  // R5: write enable only inside a chip-enable window
  assert_we_in_ce_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN);

  // R6: bus driver off whenever the memory may drive
  assert_bus_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDqOe);

  // R10: reads enable both byte lanes
  assert_read_lanes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && !memOeN) |-> (!memLbN && !memUbN));

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W           = 20,
  parameter int DATA_W           = 16,
  parameter int CLK_NS           = 4,
  parameter int T_CYCLE_NS       = 70,
  parameter int T_WE_PULSE_NS    = 45,
  parameter int T_WE_RECOV_NS    = 10,
  parameter int T_DATA_SETUP_NS  = 15,
  parameter int T_ACCESS_NS      = 65,
  parameter int T_CE_HIGH_NS     = 12,
  parameter int T_WE_GUARD_NS    = 10,
  parameter int T_OE_SETUP_NS    = 12,
  parameter int T_OUT_DIS_MAX_NS = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqBe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memLbN,
  output logic              memUbN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int CYC_CYC = ceilDiv(T_CYCLE_NS, CLK_NS);
  localparam int WP_CYC  = maxOf(ceilDiv(T_WE_PULSE_NS, CLK_NS),
                                 ceilDiv(T_DATA_SETUP_NS, CLK_NS));
  localparam int WR_CYC  = ceilDiv(T_WE_RECOV_NS, CLK_NS);
  localparam int ACC_CYC = ceilDiv(T_ACCESS_NS, CLK_NS);
  localparam int RD_LEN  = maxOf(CYC_CYC, ACC_CYC + 1);
  localparam int WR_LEN  = maxOf(CYC_CYC, WP_CYC + WR_CYC);
  localparam int GAP_LEN = maxOf(maxOf(ceilDiv(T_CE_HIGH_NS, CLK_NS),
                                       ceilDiv(T_WE_GUARD_NS, CLK_NS)),
                                 ceilDiv(T_OE_SETUP_NS, CLK_NS));
  localparam int CAP_CYC = T_OUT_DIS_MAX_NS / CLK_NS;

  pinStrobe_t stb;

  psram_ctrl_seq #(
    .WP_CYC (WP_CYC),
    .ACC_CYC(ACC_CYC),
    .RD_LEN (RD_LEN),
    .WR_LEN (WR_LEN),
    .GAP_LEN(GAP_LEN)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  psram_ctrl_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .GAP_LEN(GAP_LEN),
    .WR_CYC (WR_CYC),
    .CAP_CYC(CAP_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqBe   (reqBe),
    .rdData  (rdData),
    .rdValid (rdValid),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memLbN  (memLbN),
    .memUbN  (memUbN),
    .memDqOut(memDqOut),
    .memDqOe (memDqOe),
    .memDqIn (memDqIn)
  );

endmodule

// File: tb/psram_async_ctrl_tb.sv
module psram_async_ctrl_tb;

  localparam int CLK_NS   = 4;
  localparam int CE_MIN   = (70 + CLK_NS - 1) / CLK_NS;   // R3/R5
  localparam int WE_MIN   = (45 + CLK_NS - 1) / CLK_NS;   // R5
  localparam int RECOV    = (10 + CLK_NS - 1) / CLK_NS;   // R7
  localparam int GAP_MIN  = (12 + CLK_NS - 1) / CLK_NS;   // R8
  localparam int ACC_LAT  = (65 + CLK_NS - 1) / CLK_NS;   // R4

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        reqReady, rdValid;
  logic [15:0] rdData;
  logic [19:0] memAddr;
  logic        memCeN, memOeN, memWeN, memLbN, memUbN, memDqOe;
  logic [15:0] memDqOut;
  logic [15:0] memDqIn = 16'hBAD0;

  always #(CLK_NS / 2) clk = ~clk;

  psram_async_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memLbN(memLbN), .memUbN(memUbN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model and pin monitor, evaluated between clock edges.
  logic [15:0] mem [16];
  logic [19:0] expAddr = '0;
  int  tick = 0, accRun = 0, accStart = 0, lastLat = 0;
  int  ceLowRun = 0, ceHighRun = 100, weLowRun = 0, recovRun = 0, sinceRise = 100;
  bit  prevCeN = 1, prevWeN = 1, wroteThis = 0, latLb = 1, latUb = 1, latOe = 0;
  logic [15:0] latDq = '0;
  int  ceFalls = 0;

  always @(negedge clk) begin
    tick++;
    if (rstN) begin
      // read access-time model: poison until 65 ns of CE and OE both low
      if (!memCeN && !memOeN) accRun++; else accRun = 0;
      if (accRun == 1) accStart = tick;
      memDqIn = (accRun > 0 && (CLK_NS / 2 + CLK_NS * (accRun - 1)) >= 65)
                ? mem[memAddr[3:0]] : 16'hBAD0;
      if (rdValid) lastLat = tick - accStart;
      // write model: commit on the rising edge of write enable
      if (!memCeN && !memWeN) begin
        latDq = memDqOut; latLb = memLbN; latUb = memUbN; latOe = memDqOe;
        weLowRun++; wroteThis = 1;
      end
      if (!prevWeN && memWeN) begin
        if (!latLb) mem[memAddr[3:0]][7:0]  = latOe ? latDq[7:0]  : 8'h0F;
        if (!latUb) mem[memAddr[3:0]][15:8] = latOe ? latDq[15:8] : 8'h0F;
        chk(weLowRun >= WE_MIN, "R5 write pulse width", weLowRun, WE_MIN);
        weLowRun = 0;
      end
      // pin rules
      if (!memCeN && memAddr != expAddr) chk(0, "R2 address held", memAddr, expAddr);
      if (!memOeN && memDqOe) chk(0, "R6 driver on under OE", memDqOe, 0);
      if (!memCeN && (memDqOe != !memWeN)) chk(0, "R6 driver follows WE", memDqOe, !memWeN);
      if (!memCeN && !memOeN && (memLbN || memUbN))
        chk(0, "R10 read lanes", {memUbN, memLbN}, 0);
      if (sinceRise < GAP_MIN && (!memWeN || !memOeN))
        chk(0, "R8 quiet after CE rise", {memWeN, memOeN}, 3);
      if (!prevCeN && memCeN) begin
        chk(ceLowRun >= CE_MIN, "R3/R5 CE low width", ceLowRun, CE_MIN);
        if (wroteThis) chk(recovRun >= RECOV, "R7 write recovery", recovRun, RECOV);
        sinceRise = 0; wroteThis = 0;
      end
      if (prevCeN && !memCeN) begin
        chk(ceHighRun >= GAP_MIN, "R8 CE high gap", ceHighRun, GAP_MIN);
        ceFalls++;
      end
      if (!memCeN) begin
        ceLowRun++; ceHighRun = 0;
        if (memWeN && wroteThis) recovRun++; else recovRun = 0;
      end else begin
        ceLowRun = 0; ceHighRun++; recovRun = 0; sinceRise++;
      end
      prevCeN = memCeN; prevWeN = memWeN;
    end
  end

  task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be; reqValid = 1'b1; expAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R2 ready low while busy", reqReady, 0);
  endtask

  task automatic readWord(input logic [19:0] a, input logic [1:0] be,
                          input logic [15:0] exp, input string tag);
    int n = 0;
    issue(1'b0, a, 16'h0, be);
    while (!rdValid && n < 200) begin @(negedge clk); n++; end
    chk(rdData == exp, tag, rdData, exp);
    @(negedge clk);
    chk(!rdValid, "R4 valid one cycle", rdValid, 0);
    chk(lastLat == ACC_LAT, "R4 sample latency", lastLat, ACC_LAT);
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    chk({memCeN, memOeN, memWeN, memLbN, memUbN} == 5'h1F, "R1 pins idle in reset",
        {memCeN, memOeN, memWeN, memLbN, memUbN}, 5'h1F);
    chk(!memDqOe && !rdValid, "R1 driver and valid low", {memDqOe, rdValid}, 0);
    chk(!reqReady, "R1 not ready in reset", reqReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqReady, "R1 guard after reset", reqReady, 0);
    chk(memCeN, "R1 CE high after reset", memCeN, 1);
  endtask

  task automatic tWordWriteRead();
    int f0 = ceFalls;
    issue(1'b1, 20'h00005, 16'hA5C3, 2'b11);
    readWord(20'h00005, 2'b11, 16'hA5C3, "R3 word read back");
    chk(ceFalls - f0 == 2, "R2 one access per request", ceFalls - f0, 2);
  endtask

  task automatic tByteLanes();
    issue(1'b1, 20'h00007, 16'h1111, 2'b11);
    issue(1'b1, 20'h00007, 16'hAB22, 2'b10);
    issue(1'b1, 20'h00007, 16'h33CD, 2'b01);
    readWord(20'h00007, 2'b11, 16'hABCD, "R5 lane merge");
  endtask

  task automatic tReadMaskIgnored();
    readWord(20'h00007, 2'b00, 16'hABCD, "R10 read ignores mask");
    readWord(20'h00007, 2'b01, 16'hABCD, "R10 read ignores partial mask");
  endtask

  task automatic tBackToBack();
    issue(1'b1, 20'h00009, 16'h5A5A, 2'b11);
    issue(1'b1, 20'h0000A, 16'hC0DE, 2'b11);
    readWord(20'h00009, 2'b11, 16'h5A5A, "R6 write then read turnaround");
    readWord(20'h0000A, 2'b11, 16'hC0DE, "R8 read after read");
  endtask

  task automatic tAddrMax();
    issue(1'b1, 20'hFFFFF, 16'h0F1E, 2'b11);
    readWord(20'hFFFFF, 2'b11, 16'h0F1E, "R2 top address");
  endtask

  task automatic tIdleCe();
    bit sawLow = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!memCeN || !reqReady) sawLow = 1;
    end
    chk(!sawLow, "R9 CE high while idle", sawLow, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    tReset();
    tWordWriteRead();
    tByteLanes();
    tReadMaskIgnored();
    tBackToBack();
    tAddrMax();
    tIdleCe();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule